// File: doc/BRIEF.md
# Strobed Output Handshake Channel

This block is one latched output channel of a parallel I/O port, with a two-wire handshake towards a peripheral. A one-cycle host write pulse stores a data byte in the channel latch and pulls the active-low buffer-full line low. The peripheral drops its active-low acknowledge line when it takes the byte, which releases buffer-full. When acknowledge returns high, the block raises an interrupt request if the interrupt-enable flip-flop is set. The next host write clears that request. The interrupt-enable flip-flop is written by bit set/reset commands that name a port C bit number. Only the bit that the port mapping reserves for this channel has any effect.

The handshake lines go out on an 8-bit port C image. The parameters decide which bit carries buffer-full, which bit carries the interrupt request and which bit number controls interrupt enable. With these parameters one design serves either the A or the B channel of a port. With the bidirectional variant selected, the data pins drive only while acknowledge is held low, and the same pins stay free for strobed input the rest of the time. Otherwise the pins drive the latch all the time. The acknowledge input is asynchronous. It passes through a synchronizer before its edges are detected.

The state machine has four states. EMPTY: no byte waiting, and the state after reset. FULL: a byte is waiting. ACK_HELD: the peripheral holds acknowledge low. DONE: the transfer has ended. The transitions are:
- load: EMPTY, DONE or ACK_HELD to FULL on a host write.
- overwrite: FULL to FULL on a host write.
- take: FULL to ACK_HELD on a falling edge of acknowledge.
- finish: ACK_HELD to DONE on a rising edge of acknowledge.

Acknowledge edges seen in EMPTY or DONE have no effect.

Top module: `hs_out_chan`

## Requirements
- R1: After reset, buffer-full is high, the interrupt request is low, interrupt enable is clear and the state is EMPTY. In the bidirectional variant the pin output-enable is low.
- R2: A host write pulse latches `wr_data` onto `pin_out` and drives buffer-full low on the clock edge that samples the pulse.
- R3: A falling edge of `ack_n` in FULL returns buffer-full high on the third rising clock edge after the input falls: two synchronizer stages, then the state register.
- R4: A rising edge of `ack_n` in ACK_HELD moves the block to DONE on the third clock edge. The interrupt request is high in DONE exactly when interrupt enable is set, and it is never high while buffer-full is low.
- R5: A host write clears the interrupt request on the edge that samples it.
- R6: A host write while buffer-full is already low replaces the latch contents and keeps buffer-full low. The latch holds its value between writes.
- R7: With BIDIR=1, `pin_oe` is high only in ACK_HELD. It rises three edges after `ack_n` falls and drops three edges after `ack_n` rises.
- R8: With BIDIR=0, `pin_oe` is always high and `pin_out` always shows the latch.
- R9: A set/reset command whose 3-bit bit number equals INTE_BIT loads interrupt enable from `bsr_val` (1 sets it, 0 clears it). A command naming any other bit has no effect.
- R10: `pc_drive[OBF_BIT]` carries buffer-full and `pc_drive[INTR_BIT]` carries the interrupt request. `pc_drive_en` is high on exactly those two bits. The port A mapping is OBF_BIT=7, INTR_BIT=3, INTE_BIT=6. The port B mapping is OBF_BIT=1, INTR_BIT=0, INTE_BIT=2.
- R11: An acknowledge pulse in EMPTY is ignored: buffer-full stays high and no interrupt is raised, even with interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle host write pulse |
| wr_data | input | DATA_W | Byte to latch |
| bsr_stb | input | 1 | Bit set/reset command pulse |
| bsr_sel | input | 3 | Port C bit number named by the command |
| bsr_val | input | 1 | 1 sets, 0 clears |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| pin_out | output | DATA_W | Data pin value (the latch) |
| pin_oe | output | 1 | Data pin output enable |
| pc_drive | output | PC_W | Port C image carrying buffer-full and interrupt request |
| pc_drive_en | output | PC_W | Port C bits driven by this channel |

## Verification
The bench sweeps all 256 byte values through complete write and acknowledge cycles on two instances at once: a bidirectional port A mapping and a plain port B mapping. The enable setting alternates between iterations, so the interrupt check separates an enabled DONE from a disabled one. Every sixteenth value is written twice before the acknowledge, which separates an overwrite from a plain load. The acknowledge timing is sampled both one edge before and on the edge where the outputs must change, so an extra or a missing register stage shows up. Set/reset commands to foreign bit numbers are interleaved, and an acknowledge pulse is sent in EMPTY, to show that both are ignored at the outputs.

// File: rtl/hs_out_pkg.sv
package hs_out_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_FULL     = 2'd1,
        ST_ACK_HELD = 2'd2,
        ST_DONE     = 2'd3
    } hs_state_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hs_edge.sv
module hs_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic fall,
    output logic rise
);
    logic level_d;

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b1;
        else     level_d <= level;
    end

    assign fall = level_d & ~level;
    assign rise = ~level_d & level;
endmodule

// File: rtl/hs_inte.sv
module hs_inte #(
    parameter int INTE_BIT = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bsr_stb,
    input  logic [2:0] bsr_sel,
    input  logic       bsr_val,
    output logic       inte
);
    localparam logic [2:0] SEL = 3'(INTE_BIT);

    always_ff @(posedge clk) begin
        if (rst)                           inte <= 1'b0;
        else if (bsr_stb && bsr_sel == SEL) inte <= bsr_val;
    end
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
    import hs_out_pkg::*;
#(
    parameter bit BIDIR = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic ack_fall,
    input  logic ack_rise,
    input  logic inte,
    output logic obf_n,
    output logic intr,
    output logic oe
);
    hs_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY:    if (wr_stb) state_nx = ST_FULL;
            ST_FULL:     if (wr_stb) state_nx = ST_FULL;
                         else if (ack_fall) state_nx = ST_ACK_HELD;
            ST_ACK_HELD: if (wr_stb) state_nx = ST_FULL;
                         else if (ack_rise) state_nx = ST_DONE;
            ST_DONE:     if (wr_stb) state_nx = ST_FULL;
            default:     state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    always_comb begin
        obf_n = 1'b1;
        intr  = 1'b0;
        oe    = (BIDIR == 1'b0);
        unique case (state)
            ST_EMPTY:    ;
            ST_FULL:     obf_n = 1'b0;
            ST_ACK_HELD: oe = 1'b1;
            ST_DONE:     intr = inte;
            default:     obf_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan #(
    parameter int DATA_W      = 8,
    parameter int PC_W        = 8,
    parameter int OBF_BIT     = 7,
    parameter int INTR_BIT    = 3,
    parameter int INTE_BIT    = 6,
    parameter bit BIDIR       = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bsr_stb,
    input  logic [2:0]        bsr_sel,
    input  logic              bsr_val,
    input  logic              ack_n,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_oe,
    output logic [PC_W-1:0]   pc_drive,
    output logic [PC_W-1:0]   pc_drive_en
);
    logic ack_s, ack_fall, ack_rise, inte, obf_n, intr;
    logic [DATA_W-1:0] latch_q;

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk(clk), .rst(rst), .din(ack_n), .dout(ack_s)
    );

    hs_edge i_edge (
        .clk(clk), .rst(rst), .level(ack_s), .fall(ack_fall), .rise(ack_rise)
    );

    hs_inte #(.INTE_BIT(INTE_BIT)) i_inte (
        .clk(clk), .rst(rst), .bsr_stb(bsr_stb), .bsr_sel(bsr_sel),
        .bsr_val(bsr_val), .inte(inte)
    );

    hs_fsm #(.BIDIR(BIDIR)) i_fsm (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .ack_fall(ack_fall),
        .ack_rise(ack_rise), .inte(inte), .obf_n(obf_n), .intr(intr), .oe(pin_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)         latch_q <= '0;
        else if (wr_stb) latch_q <= wr_data;
    end
    assign pin_out = latch_q;

    generate
        for (genvar b = 0; b < PC_W; b++) begin : g_pc
            if (b == OBF_BIT) begin : g_obf
                assign pc_drive[b]    = obf_n;
                assign pc_drive_en[b] = 1'b1;
            end else if (b == INTR_BIT) begin : g_intr
                assign pc_drive[b]    = intr;
                assign pc_drive_en[b] = 1'b1;
            end else begin : g_free
                assign pc_drive[b]    = 1'b0;
                assign pc_drive_en[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/hs_out_chan_chk.sv
module hs_out_chan_chk #(
    parameter int DATA_W   = 8,
    parameter int PC_W     = 8,
    parameter int OBF_BIT  = 7,
    parameter int INTR_BIT = 3,
    parameter bit BIDIR    = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] pin_out,
    input logic              pin_oe,
    input logic [PC_W-1:0]   pc_drive
);
    assert_wr_full_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !pc_drive[OBF_BIT]);

    assert_wr_data_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> pin_out == $past(wr_data));

    assert_intr_empty_R4: assert property (@(posedge clk) disable iff (rst)
        pc_drive[INTR_BIT] |-> pc_drive[OBF_BIT]);

    assert_wr_clr_intr_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !pc_drive[INTR_BIT]);

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(pin_out));

    assert_oe_held_R7: assert property (@(posedge clk) disable iff (rst)
        (BIDIR && pin_oe) |-> (pc_drive[OBF_BIT] && !pc_drive[INTR_BIT]));

    assert_oe_plain_R8: assert property (@(posedge clk) disable iff (rst)
        (!BIDIR && wr_stb) |=> pin_oe);
endmodule

bind hs_out_chan hs_out_chan_chk #(
    .DATA_W(DATA_W), .PC_W(PC_W), .OBF_BIT(OBF_BIT),
    .INTR_BIT(INTR_BIT), .BIDIR(BIDIR)
) i_chk (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .pin_out(pin_out), .pin_oe(pin_oe), .pc_drive(pc_drive)
);

// File: tb/test_hs_out_chan.sv
module test_hs_out_chan;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic bsr_stb = 1'b0;
    logic [2:0] bsr_sel = '0;
    logic bsr_val = 1'b0;
    logic ack_n = 1'b1;
    logic [7:0] pin_a, pin_b, pc_a, pc_b, pce_a, pce_b;
    logic oe_a, oe_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_out_chan #(.OBF_BIT(7), .INTR_BIT(3), .INTE_BIT(6), .BIDIR(1'b1)) i_hs_out_chan (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .bsr_stb(bsr_stb),
        .bsr_sel(bsr_sel), .bsr_val(bsr_val), .ack_n(ack_n), .pin_out(pin_a),
        .pin_oe(oe_a), .pc_drive(pc_a), .pc_drive_en(pce_a)
    );

    hs_out_chan #(.OBF_BIT(1), .INTR_BIT(0), .INTE_BIT(2), .BIDIR(1'b0)) i_hs_out_chan_pb (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .bsr_stb(bsr_stb),
        .bsr_sel(bsr_sel), .bsr_val(bsr_val), .ack_n(ack_n), .pin_out(pin_b),
        .pin_oe(oe_b), .pc_drive(pc_b), .pc_drive_en(pce_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_stb = 1'b1; wr_data = v;
        tick(1);
        wr_stb = 1'b0;
    endtask

    task automatic do_bsr(input logic [2:0] sel, input logic val);
        bsr_stb = 1'b1; bsr_sel = sel; bsr_val = val;
        tick(1);
        bsr_stb = 1'b0;
    endtask

    // Obf/intr read through the mapped bits (R10)
    function automatic logic [3:0] hs_bits();
        return {pc_a[7], pc_a[3], pc_b[1], pc_b[0]};
    endfunction

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 obf/intr", hs_bits(), 4'b1010);
        chk("R1 oe bidir", oe_a, 1'b0);
        chk("R8 oe plain", oe_b, 1'b1);
        // R10 mapping
        chk("R10 enables A", pce_a, 8'h88);
        chk("R10 enables B", pce_b, 8'h03);
        // R1 interrupt enable clear: a full transfer gives no interrupt
        do_write(8'h11);
        ack_n = 1'b0; tick(4); ack_n = 1'b1; tick(4);
        chk("R1 inte clear", hs_bits(), 4'b1010);
        // R11 ack pulse while empty ignored
        rst = 1'b1; tick(1); rst = 1'b0;
        do_bsr(3'd6, 1'b1); do_bsr(3'd2, 1'b1);
        ack_n = 1'b0; tick(4); ack_n = 1'b1; tick(4);
        chk("R11 empty ack", hs_bits(), 4'b1010);
        chk("R11 oe", oe_a, 1'b0);

        for (int v = 0; v < 256; v++) begin
            logic en;
            logic [7:0] exp_d;
            en = v[1];
            do_bsr(3'd6, en); do_bsr(3'd2, en);
            if (!en) begin
                do_bsr(3'd5, 1'b1); do_bsr(3'd1, 1'b1); // R9 foreign bits
            end
            exp_d = 8'(v);
            do_write(exp_d);
            chk("R2 obf low", hs_bits(), 4'b0000);
            chk("R2 data B", pin_b, exp_d);
            chk("R7 oe off while full", oe_a, 1'b0);
            if (v % 16 == 0) begin
                exp_d = ~exp_d;
                do_write(exp_d);
                chk("R6 obf stays low", hs_bits(), 4'b0000);
                chk("R6 data replaced", pin_b, exp_d);
            end
            ack_n = 1'b0;
            tick(2);
            chk("R3 obf before", hs_bits(), 4'b0000);
            chk("R7 oe before", oe_a, 1'b0);
            tick(1);
            chk("R3 obf released", hs_bits(), 4'b1010);
            chk("R7 oe on", oe_a, 1'b1);
            chk("R7 data A", pin_a, exp_d);
            chk("R8 oe plain", oe_b, 1'b1);
            ack_n = 1'b1;
            tick(2);
            chk("R4 intr before", hs_bits(), 4'b1010);
            chk("R7 oe still on", oe_a, 1'b1);
            tick(1);
            chk(en ? "R4 intr enabled" : "R9 intr disabled", hs_bits(), {1'b1, en, 1'b1, en});
            chk("R7 oe off", oe_a, 1'b0);
            if (en) begin
                do_bsr(3'd7, 1'b0); do_bsr(3'd3, 1'b0);
                chk("R9 foreign clear ignored", hs_bits(), 4'b1111);
            end
            do_write(8'h5A);
            chk("R5 intr cleared", hs_bits(), 4'b0000);
            ack_n = 1'b0; tick(3); ack_n = 1'b1; tick(3);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule